// File: doc/BRIEF.md
# Write-masked PLL control register bank

This block holds the configuration and status words for a fractional-N frequency synthesizer. Software reaches it through a plain word bus: an address, a write strobe with write data, and a read-data return that is valid in the same cycle as the address. The bank drives every divider value, the fractional word, the fractional-bypass flag and the power-down flag straight to the synthesizer. It also reports the synthesizer's lock indication back to software.

Two of the words use a per-bit write mask carried in the top half of the write data. Software can change one field without reading the word first, and without racing another agent that writes a different field of the same word. The fractional word has no spare upper half, so it takes ordinary full-word writes. The lock indication comes from another clock domain and passes through a short synchronizer before it can be read. Software cannot write it.

Top module: `pllcfg_bank`

## Requirements
- R1: After reset, word 0 reads 0x00001001, word 1 reads 0x00003041 while lock is low, and word 2 reads 0. Every divider output is 1, frac_bypass is 1, pwr_dn is 1, pll_en is 0 and frac_word is 0.
- R2: In words 0 and 1, a write changes stored bit i (0..15) only when write-data bit i+16 is 1, and then takes write-data bit i. Read bits 31:16 of these words are always 0.
- R3: Word 0 (byte address 0x0) holds the feedback divider in bits 11:0 and the first post-divider in bits 14:12. These values appear on fb_div and post_div_a.
- R4: Word 1 (byte address 0x4) holds the reference divider in bits 5:0, the second post-divider in bits 8:6, the fractional bypass in bit 12 and power-down in bit 13. These values appear on ref_div, post_div_b, frac_bypass and pwr_dn.
- R5: Bit 10 of word 1 reads the lock_in input after SYNC_STAGES rising clock edges (2 by default). Writes to that bit, masked or not, have no effect.
- R6: Word 2 (byte address 0x8) takes write-data bits 23:0 on every write, with no masking. It drives frac_word. Bits 31:24 read 0.
- R7: pll_en is the inverse of pwr_dn. Only a write to word 1 can change pwr_dn.
- R8: Word 3 (byte address 0xC), bit 15 of word 0 and bits 9, 11, 14 and 15 of word 1 read 0. Writes to them have no effect.
- R9: rd_data follows addr combinationally. A write becomes visible from the clock edge that accepts it, so a read of the same word in the writing cycle still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address; bits 3:2 pick the word, bits 1:0 are ignored |
| wr_en | input | 1 | Write strobe, accepted at the rising edge |
| wr_data | input | 32 | Write data; bits 31:16 are the mask for masked words |
| rd_data | output | 32 | Read data for the addressed word |
| lock_in | input | 1 | Lock indication from the synthesizer, asynchronous |
| fb_div | output | 12 | Feedback divider |
| post_div_a | output | 3 | First post-divider |
| ref_div | output | 6 | Reference divider |
| post_div_b | output | 3 | Second post-divider |
| frac_bypass | output | 1 | 1 selects integer mode |
| frac_word | output | 24 | Fractional part of the feedback ratio |
| pwr_dn | output | 1 | 1 powers the synthesizer down |
| pll_en | output | 1 | Enabled status, inverse of pwr_dn |

## Verification
A write to word 1 and a change of the lock input can land in the same cycle. Both touch the same read word, one through the mask merge and the other through the synchronizer. The bench writes word 1 with the mask bit for bit 10 set and the data bit at the opposite value, while lock_in toggles in that same cycle. It then reads word 1 on each following cycle. The stored fields must stay unchanged, and bit 10 must follow the synchronized lock input with exactly the synchronizer's delay. A write and a read of the same word in one cycle are also judged, to confirm that the old value is returned until the edge.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

    localparam int HALF_W   = 16;
    localparam int WORD_W   = 32;
    localparam int FB_W     = 12;
    localparam int PA_W     = 3;
    localparam int REF_W    = 6;
    localparam int PB_W     = 3;
    localparam int FRAC_W   = 24;

    // bit positions inside the stored halfwords
    localparam int FB_LSB   = 0;
    localparam int PA_LSB   = FB_LSB + FB_W;
    localparam int REF_LSB  = 0;
    localparam int PB_LSB   = REF_LSB + REF_W;
    localparam int LOCK_BIT = 10;
    localparam int BYP_BIT  = 12;
    localparam int PD_BIT   = 13;

    // implemented (writable) bits of the masked words
    localparam logic [HALF_W-1:0] W0_IMPL =
        HALF_W'(((1 << (FB_W + PA_W)) - 1) << FB_LSB);
    localparam logic [HALF_W-1:0] W1_IMPL =
        HALF_W'(((1 << (REF_W + PB_W)) - 1) << REF_LSB) |
        HALF_W'(1 << BYP_BIT) | HALF_W'(1 << PD_BIT);

    // reset: every divider at 1, integer mode, powered down
    localparam logic [HALF_W-1:0] W0_RST =
        HALF_W'(1 << PA_LSB) | HALF_W'(1 << FB_LSB);
    localparam logic [HALF_W-1:0] W1_RST =
        HALF_W'(1 << PD_BIT) | HALF_W'(1 << BYP_BIT) |
        HALF_W'(1 << PB_LSB) | HALF_W'(1 << REF_LSB);
    localparam logic [FRAC_W-1:0] FRAC_RST = '0;

    typedef enum logic [1:0] {
        SEL_DIV  = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_FRAC = 2'd2,
        SEL_NONE = 2'd3
    } word_sel_e;

    typedef struct packed {
        logic [HALF_W-1:0] w0;
        logic [HALF_W-1:0] w1;
        logic [FRAC_W-1:0] frac;
    } bank_state_t;

endpackage

// File: rtl/pllcfg_hwmask.sv
module pllcfg_hwmask
    import pllcfg_pkg::*;
#(
    parameter logic [HALF_W-1:0] IMPL = '1
) (
    input  logic [HALF_W-1:0] cur,
    input  logic [WORD_W-1:0] wdata,
    output logic [HALF_W-1:0] nxt
);

    logic [HALF_W-1:0] unused_bits;

    for (genvar i = 0; i < HALF_W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            assign nxt[i]         = wdata[i + HALF_W] ? wdata[i] : cur[i];
            assign unused_bits[i] = 1'b0;
        end else begin : g_hole
            assign nxt[i]         = 1'b0;
            assign unused_bits[i] = cur[i] ^ wdata[i] ^ wdata[i + HALF_W];
        end
    end

endmodule

// File: rtl/pllcfg_sync.sv
module pllcfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/pllcfg_regs.sv
module pllcfg_regs
    import pllcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  word_sel_e         sel,
    input  logic [WORD_W-1:0] wr_data,
    output bank_state_t       state_q
);

    bank_state_t       state_d;
    logic [HALF_W-1:0] w0_merged;
    logic [HALF_W-1:0] w1_merged;
    logic [WORD_W-FRAC_W-1:0] unused_top;

    pllcfg_hwmask #(.IMPL(W0_IMPL)) i_mask_w0 (
        .cur   (state_q.w0),
        .wdata (wr_data),
        .nxt   (w0_merged)
    );

    pllcfg_hwmask #(.IMPL(W1_IMPL)) i_mask_w1 (
        .cur   (state_q.w1),
        .wdata (wr_data),
        .nxt   (w1_merged)
    );

    assign unused_top = wr_data[WORD_W-1:FRAC_W];

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            case (sel)
                SEL_DIV:  state_d.w0   = w0_merged;
                SEL_CFG:  state_d.w1   = w1_merged;
                SEL_FRAC: state_d.frac = wr_data[FRAC_W-1:0];
                default:  state_d      = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.w0   <= W0_RST;
            state_q.w1   <= W1_RST;
            state_q.frac <= FRAC_RST;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/pllcfg_bank.sv
module pllcfg_bank
    import pllcfg_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic              lock_in,
    output logic [11:0]       fb_div,
    output logic [2:0]        post_div_a,
    output logic [5:0]        ref_div,
    output logic [2:0]        post_div_b,
    output logic              frac_bypass,
    output logic [23:0]       frac_word,
    output logic              pwr_dn,
    output logic              pll_en
);

    localparam int WORD_LSB = 2;
    localparam int SEL_W    = 2;
    localparam int DEC_TOP  = WORD_LSB + SEL_W;

    bank_state_t state_q;
    word_sel_e   sel;
    logic        hi_ok;
    logic        lock_s;
    logic        wr_hit;
    logic [1:0]  unused_lsb;

    assign unused_lsb = addr[WORD_LSB-1:0];
    assign sel        = word_sel_e'(addr[WORD_LSB +: SEL_W]);

    if (ADDR_W > DEC_TOP) begin : g_hi
        assign hi_ok = ~|addr[ADDR_W-1:DEC_TOP];
    end else begin : g_nohi
        assign hi_ok = 1'b1;
    end

    assign wr_hit = wr_en & hi_ok;

    pllcfg_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_hit),
        .sel     (sel),
        .wr_data (wr_data),
        .state_q (state_q)
    );

    pllcfg_sync #(.STAGES(SYNC_STAGES)) i_lock_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (lock_in),
        .dout  (lock_s)
    );

    always_comb begin
        rd_data = '0;
        if (hi_ok) begin
            case (sel)
                SEL_DIV:  rd_data[HALF_W-1:0] = state_q.w0;
                SEL_CFG: begin
                    rd_data[HALF_W-1:0] = state_q.w1;
                    rd_data[LOCK_BIT]   = lock_s;
                end
                SEL_FRAC: rd_data[FRAC_W-1:0] = state_q.frac;
                default:  rd_data = '0;
            endcase
        end
    end

    assign fb_div      = state_q.w0[FB_LSB +: FB_W];
    assign post_div_a  = state_q.w0[PA_LSB +: PA_W];
    assign ref_div     = state_q.w1[REF_LSB +: REF_W];
    assign post_div_b  = state_q.w1[PB_LSB +: PB_W];
    assign frac_bypass = state_q.w1[BYP_BIT];
    assign pwr_dn      = state_q.w1[PD_BIT];
    assign pll_en      = ~state_q.w1[PD_BIT];
    assign frac_word   = state_q.frac;

endmodule

// File: rtl/pllcfg_bank_chk.sv
module pllcfg_bank_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [31:0]       wr_data,
    input logic [31:0]       rd_data,
    input logic [11:0]       fb_div,
    input logic [2:0]        post_div_a,
    input logic [5:0]        ref_div,
    input logic [2:0]        post_div_b,
    input logic              frac_bypass,
    input logic [23:0]       frac_word,
    input logic              pwr_dn
);

    // no write, no change of any exported field
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(fb_div) && $stable(post_div_a) && $stable(ref_div) &&
                    $stable(post_div_b) && $stable(frac_bypass) && $stable(pwr_dn) &&
                    $stable(frac_word)));

    // word 0 written with an all-zero mask keeps its fields
    p_zero_mask_w0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0) && wr_data[30:16] == 15'd0)
        |=> ($stable(fb_div) && $stable(post_div_a)));

    // fractional word takes the whole low 24 bits
    p_frac_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8)) |=> (frac_word == $past(wr_data[23:0])));

    // power-down moves only through word 1
    p_pd_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_W'(4)) |=> $stable(pwr_dn));

    // unused word reads zero
    p_hole_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(12)) |-> (rd_data == 32'd0));

    // upper byte never carries data
    p_top_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:24] == 8'd0);

endmodule

bind pllcfg_bank pllcfg_bank_chk #(.ADDR_W(ADDR_W)) i_pllcfg_bank_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .fb_div      (fb_div),
    .post_div_a  (post_div_a),
    .ref_div     (ref_div),
    .post_div_b  (post_div_b),
    .frac_bypass (frac_bypass),
    .frac_word   (frac_word),
    .pwr_dn      (pwr_dn)
);

// File: tb/test_pllcfg_bank.sv
`timescale 1ns/1ps
module test_pllcfg_bank;

    localparam int ADDR_W = 4;
    localparam int NVEC   = 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic [31:0]       wr_data;
    logic [31:0]       rd_data;
    logic              lock_in;
    logic [11:0]       fb_div;
    logic [2:0]        post_div_a;
    logic [5:0]        ref_div;
    logic [2:0]        post_div_b;
    logic              frac_bypass;
    logic [23:0]       frac_word;
    logic              pwr_dn;
    logic              pll_en;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pllcfg_bank #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) i_pllcfg_bank (
        .clk (clk), .rst_n (rst_n), .addr (addr), .wr_en (wr_en),
        .wr_data (wr_data), .rd_data (rd_data), .lock_in (lock_in),
        .fb_div (fb_div), .post_div_a (post_div_a), .ref_div (ref_div),
        .post_div_b (post_div_b), .frac_bypass (frac_bypass),
        .frac_word (frac_word), .pwr_dn (pwr_dn), .pll_en (pll_en)
    );

    // {write addr, write data, read addr, expected read}
    localparam logic [71:0] VEC [NVEC] = '{
        {4'h0, 32'hFFFF0ABC, 4'h0, 32'h00000ABC},  // R3 full write word 0
        {4'h0, 32'h70005FFF, 4'h0, 32'h00005ABC},  // R2 only post-div bits masked in
        {4'h0, 32'h0000FFFF, 4'h0, 32'h00005ABC},  // R2 empty mask
        {4'h0, 32'h80008000, 4'h0, 32'h00005ABC},  // R8 unimplemented bit 15
        {4'h4, 32'hFFFF0000, 4'h4, 32'h00000000},  // R4 clear all of word 1
        {4'h4, 32'h3FFF3FFF, 4'h4, 32'h000031FF},  // R5 bit 10 not stored, R8 holes
        {4'h4, 32'h00400000, 4'h4, 32'h000031BF},  // R2 single bit clear
        {4'h8, 32'hDEADBEEF, 4'h8, 32'h00ADBEEF},  // R6 full word, top byte dropped
        {4'h8, 32'h00000001, 4'h8, 32'h00000001},  // R6 no mask semantics
        {4'hC, 32'hFFFFFFFF, 4'hC, 32'h00000000},  // R8 word 3 reads zero
        {4'hC, 32'hFFFFFFFF, 4'h0, 32'h00005ABC},  // R8 word 3 write harmless
        {4'h4, 32'h20000000, 4'h4, 32'h000011BF}   // R7 power up
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic check_reset_state();
        read_chk("R1 word0", 4'h0, 32'h00001001);
        read_chk("R1 word1", 4'h4, 32'h00003041);
        read_chk("R1 word2", 4'h8, 32'h00000000);
        check("R1 dividers", {20'd0, fb_div, post_div_a, ref_div, post_div_b},
              {20'd0, 12'd1, 3'd1, 6'd1, 3'd1});
        check("R1 flags", {29'd0, frac_bypass, pwr_dn, pll_en}, 32'h6);
        check("R1 frac", {8'd0, frac_word}, 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_data = '0; lock_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        for (int k = 0; k < NVEC; k++) begin
            do_write(VEC[k][71:68], VEC[k][67:36]);
            read_chk("R2 table vector", VEC[k][35:32], VEC[k][31:0]);
        end

        // R3 R4 exported fields after the table
        check("R3 fields", {17'd0, post_div_a, fb_div}, {17'd0, 3'd5, 12'hABC});
        check("R4 fields", {20'd0, ref_div, post_div_b, frac_bypass, pwr_dn},
              {20'd0, 6'h3F, 3'd6, 1'b1, 1'b0});
        check("R7 enabled", {31'd0, pll_en}, 32'd1);
        check("R6 port", {8'd0, frac_word}, 32'd1);

        // R5 lock latency through the synchronizer
        @(negedge clk);
        lock_in = 1'b1; addr = 4'h4;
        #1 check("R5 lock before edge", rd_data, 32'h000011BF);
        @(negedge clk);
        #1 check("R5 lock after one edge", rd_data, 32'h000011BF);
        @(negedge clk);
        #1 check("R5 lock after two edges", rd_data, 32'h000015BF);

        // R5 write to lock bit in the same cycle as lock falls
        @(negedge clk);
        addr = 4'h4; wr_data = 32'h04000000; wr_en = 1'b1; lock_in = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R5 collision first edge", rd_data, 32'h000015BF);
        @(negedge clk);
        #1 check("R5 collision second edge", rd_data, 32'h000011BF);
        do_write(4'h4, 32'h04000400);
        read_chk("R5 set attempt ignored", 4'h4, 32'h000011BF);

        // R9 same-cycle read returns old data
        @(negedge clk);
        addr = 4'h8; wr_data = 32'h00000005; wr_en = 1'b1;
        #1 check("R9 old value in write cycle", rd_data, 32'h00000001);
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R9 new value after edge", rd_data, 32'h00000005);

        // R7 power down again
        do_write(4'h4, 32'h20002000);
        #1 check("R7 powered down", {30'd0, pwr_dn, pll_en}, 32'h2);
        read_chk("R7 word1", 4'h4, 32'h000031BF);

        // R1 second reset restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule